// File: doc/BRIEF.md
# SPI Slave Framed Message Port

This block is a mode-0 SPI slave that trades one fixed-size message frame with a host on every transaction. A transaction runs from chip select going low to chip select going high. The frame is 29 bytes long. On the chip side it holds a code byte, an id byte, a 24-octet payload, a tail byte and a 16-bit check word. The port treats all 29 bytes as opaque storage.

While the host clocks bytes in, the port shifts a prepared transmit frame out on MISO. If transmit is not armed, it sends the filler byte 0xFE in place of each frame byte. Incoming bytes are written into a receive frame buffer. If the first byte of a transaction is the poll code 0x00, the earlier request in the receive buffer is left untouched.

When chip select is released after a non-poll frame that arrived with receive enabled, the port raises a done flag for the local logic. The local logic then reads the receive buffer through a parallel read port. While it reads, it holds receive disabled so the buffer cannot change. Raising the receive enable again clears the flag.

SCK, MOSI and chip select are brought into the system clock domain through a two-stage synchronizer. All edge detection happens in the system clock domain.

Top module: `spi_frame_port`

## Requirements
- R1: Mode 0 applies. MOSI is sampled on each SCK rising edge, most significant bit first. MISO moves to its next bit only after an SCK falling edge.
- R2: When chip select falls, the first byte is placed on MISO before the first SCK rise. This byte is transmit frame byte 0 when `txArm` is high, otherwise 0xFE.
- R3: After received byte k (k counted from 0), the next byte on MISO is transmit frame byte k+1 when `txArm` is high and k+1 < 29. Otherwise it is 0xFE.
- R4: A transaction whose first received byte is 0x00 writes nothing into the receive buffer and does not set `frameDone`.
- R5: Received byte k is stored at receive address k only while `rxEnable` is high and the transaction is not a poll. Bytes with k ≥ 29 are discarded.
- R6: `misoOe` is high while the transaction is active and low after chip select rises. At that release, `frameDone` is set if the first byte was non-zero and `rxEnable` is high.
- R7: A rising edge on `rxEnable` clears `frameDone` on the next clock. The clear takes priority over a set in the same cycle.
- R8: While `rxEnable` stays low, `rxRdData` at a fixed `rxRdAddr` does not change.
- R9: A transmit byte written through `txWrEn`/`txWrAddr`/`txWrData` (addresses 0 to 28) is the byte sent at that frame position.
- R10: After reset, `misoOe` and `frameDone` are low and every receive buffer byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | SPI serial clock from host |
| mosiIn | input | 1 | Serial data from host |
| ssNIn | input | 1 | Active-low chip select |
| misoOut | output | 1 | Serial data to host |
| misoOe | output | 1 | MISO drive enable (high while selected) |
| txArm | input | 1 | Send the transmit frame instead of filler |
| txWrEn | input | 1 | Transmit buffer write strobe |
| txWrAddr | input | 5 | Transmit buffer byte address |
| txWrData | input | 8 | Transmit buffer write byte |
| rxEnable | input | 1 | Allow capture into the receive buffer |
| rxRdAddr | input | 5 | Receive buffer byte address |
| rxRdData | output | 8 | Receive buffer byte at `rxRdAddr` |
| frameDone | output | 1 | A non-poll frame was captured |

## Verification
The bench sweeps a set of transactions with different lengths: an empty select, 1 byte, 5 bytes, exactly 29 bytes and 31 bytes. Each is run with transmit armed or not armed, and with receive enabled or disabled. This separates the frame-byte/filler choice and the cut-off at the frame length from an off-by-one in the byte counter.

A poll transaction, whose first byte is zero, shows whether the first-byte decision gates both storage and the done flag. A transmit buffer rewritten between frames shows that MISO follows the buffer contents and not a fixed pattern.

After every transaction, all 29 receive bytes are compared against a model kept in the bench. Partial or extra writes are caught wherever they land.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int FRAME_BYTES = 29;
  localparam logic [7:0] FILLER_BYTE = 8'hFE;
  localparam logic [7:0] POLL_BYTE = 8'h00;

  typedef struct packed {
    logic startFrame;
    logic sampleBit;
    logic shiftEdge;
    logic byteEnd;
    logic storeEn;
  } frameStrb_t;
endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_BYTES,
  parameter logic [7:0] POLL_CODE = POLL_BYTE,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = $clog2(FRAME_LEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sckIn,
  input  logic            mosiIn,
  input  logic            ssNIn,
  input  logic            rxEnable,
  input  logic [7:0]      rxByteNow,
  output logic            mosiBit,
  output frameStrb_t      strb,
  output logic [IDXW-1:0] byteIdx,
  output logic            active,
  output logic            frameDone
);
  localparam logic [IDXW-1:0] LEN_C = IDXW'(FRAME_LEN);

  logic [SYNC_STAGES-1:0] sckPipe, mosiPipe, ssPipe;
  logic sckS, ssS, sckPrev, ssPrev, rxEnPrev;
  logic sckRise, sckFall, ssFall, ssRise, live;
  logic [2:0] bitCnt;
  logic [IDXW-1:0] byteCnt;
  logic rxBody, firstNonPoll;

  // two-flop style synchronizers, depth set by SYNC_STAGES
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sckPipe <= '0; mosiPipe <= '0; ssPipe <= '1;
        end else begin
          sckPipe <= sckIn; mosiPipe <= mosiIn; ssPipe <= ssNIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sckPipe <= '0; mosiPipe <= '0; ssPipe <= '1;
        end else begin
          sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sckIn};
          mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
          ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssNIn};
        end
    end
  endgenerate

  assign sckS    = sckPipe[SYNC_STAGES-1];
  assign ssS     = ssPipe[SYNC_STAGES-1];
  assign mosiBit = mosiPipe[SYNC_STAGES-1];

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign ssFall  = ~ssS & ssPrev;
  assign ssRise  = ssS & ~ssPrev;
  assign live    = active & ~ssRise;
  assign firstNonPoll = (rxByteNow != POLL_CODE);

  always_comb begin
    strb.startFrame = ssFall;
    strb.sampleBit  = live & sckRise;
    strb.shiftEdge  = live & sckFall;
    strb.byteEnd    = live & sckRise & (bitCnt == 3'd7);
    strb.storeEn    = strb.byteEnd & (byteCnt < LEN_C) & rxEnable &
                      ((byteCnt == '0) ? firstNonPoll : rxBody);
  end
  assign byteIdx = byteCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sckPrev <= 1'b0; ssPrev <= 1'b1; rxEnPrev <= 1'b0;
      active <= 1'b0; bitCnt <= '0; byteCnt <= '0; rxBody <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      sckPrev  <= sckS;
      ssPrev   <= ssS;
      rxEnPrev <= rxEnable;
      if (ssFall) begin
        active <= 1'b1; bitCnt <= '0; byteCnt <= '0; rxBody <= 1'b0;
      end else if (ssRise) begin
        active <= 1'b0;
      end else if (live && sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (byteCnt == '0) rxBody <= firstNonPoll;
          if (byteCnt < LEN_C) byteCnt <= byteCnt + 1'b1;
        end
      end
      if (rxEnable && !rxEnPrev)
        frameDone <= 1'b0;
      else if (ssRise && active && rxBody && rxEnable)
        frameDone <= 1'b1;
    end
endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_BYTES,
  parameter logic [7:0] FILLER = FILLER_BYTE,
  localparam int IDXW = $clog2(FRAME_LEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  frameStrb_t      strb,
  input  logic [IDXW-1:0] byteIdx,
  input  logic            mosiBit,
  input  logic            txArm,
  input  logic            txWrEn,
  input  logic [IDXW-1:0] txWrAddr,
  input  logic [7:0]      txWrData,
  input  logic [IDXW-1:0] rxRdAddr,
  output logic [7:0]      rxByteNow,
  output logic            misoBit,
  output logic [7:0]      rxRdData
);
  localparam logic [IDXW:0] LEN_W = (IDXW + 1)'(FRAME_LEN);

  logic [7:0] rxMem [FRAME_LEN];
  logic [7:0] txMem [FRAME_LEN];
  logic [7:0] rxShift, txShift, txPend;
  logic pendValid;
  logic [IDXW:0] nextIdx;

  function automatic logic [7:0] txPick(input logic [IDXW:0] k, input logic arm);
    if (arm && (k < LEN_W)) return txMem[k[IDXW-1:0]];
    return FILLER;
  endfunction

  assign rxByteNow = {rxShift[6:0], mosiBit};
  assign nextIdx   = {1'b0, byteIdx} + 1'b1;
  assign misoBit   = txShift[7];
  assign rxRdData  = ({1'b0, rxRdAddr} < LEN_W) ? rxMem[rxRdAddr] : 8'h00;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxShift <= '0;
    else if (strb.sampleBit) rxShift <= rxByteNow;

  generate
    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_mem
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          rxMem[i] <= '0;
          txMem[i] <= '0;
        end else begin
          if (strb.storeEn && byteIdx == IDXW'(i)) rxMem[i] <= rxByteNow;
          if (txWrEn && txWrAddr == IDXW'(i)) txMem[i] <= txWrData;
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txShift <= FILLER; txPend <= FILLER; pendValid <= 1'b0;
    end else if (strb.startFrame) begin
      txShift <= txPick('0, txArm);
      pendValid <= 1'b0;
    end else if (strb.byteEnd) begin
      txPend <= txPick(nextIdx, txArm);
      pendValid <= 1'b1;
    end else if (strb.shiftEdge) begin
      if (pendValid) begin
        txShift <= txPend;
        pendValid <= 1'b0;
      end else begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port
  import spi_frame_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_BYTES,
  parameter logic [7:0] FILLER = FILLER_BYTE,
  parameter logic [7:0] POLL_CODE = POLL_BYTE,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = $clog2(FRAME_LEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sckIn,
  input  logic            mosiIn,
  input  logic            ssNIn,
  output logic            misoOut,
  output logic            misoOe,
  input  logic            txArm,
  input  logic            txWrEn,
  input  logic [IDXW-1:0] txWrAddr,
  input  logic [7:0]      txWrData,
  input  logic            rxEnable,
  input  logic [IDXW-1:0] rxRdAddr,
  output logic [7:0]      rxRdData,
  output logic            frameDone
);
  frameStrb_t strb;
  logic [IDXW-1:0] byteIdx;
  logic [7:0] rxByteNow;
  logic mosiBit;

  spi_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .POLL_CODE(POLL_CODE),
                   .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .rxEnable(rxEnable), .rxByteNow(rxByteNow), .mosiBit(mosiBit),
    .strb(strb), .byteIdx(byteIdx), .active(misoOe), .frameDone(frameDone));

  spi_frame_dp #(.FRAME_LEN(FRAME_LEN), .FILLER(FILLER)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .mosiBit(mosiBit),
    .txArm(txArm), .txWrEn(txWrEn), .txWrAddr(txWrAddr), .txWrData(txWrData),
    .rxRdAddr(rxRdAddr), .rxByteNow(rxByteNow), .misoBit(misoOut),
    .rxRdData(rxRdData));
endmodule

// File: rtl/spi_frame_port_chk.sv
module spi_frame_port_chk #(
  parameter logic [7:0] FILLER = 8'hFE,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            misoOut,
  input logic            misoOe,
  input logic            txArm,
  input logic            rxEnable,
  input logic [IDXW-1:0] rxRdAddr,
  input logic [7:0]      rxRdData,
  input logic            frameDone
);
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |=> !frameDone); // R7

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> (!misoOe && $past(misoOe))); // R6

  AST_DONE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> $past(rxEnable)); // R5

  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !$past(rxEnable) && $stable(rxRdAddr)) |-> $stable(rxRdData)); // R8

  AST_FILLER_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(misoOe) && !$past(txArm)) |-> (misoOut == FILLER[7])); // R2
endmodule

bind spi_frame_port spi_frame_port_chk #(.FILLER(FILLER), .IDXW(IDXW)) chk_i (
  .clk(clk), .rstN(rstN), .misoOut(misoOut), .misoOe(misoOe), .txArm(txArm),
  .rxEnable(rxEnable), .rxRdAddr(rxRdAddr), .rxRdData(rxRdData),
  .frameDone(frameDone));

// File: tb/spi_frame_port_tb.sv
module spi_frame_port_tb_top;
  localparam int LEN = 29;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssNIn = 1'b1;
  logic misoOut, misoOe, frameDone;
  logic txArm = 1'b0, txWrEn = 1'b0, rxEnable = 1'b0;
  logic [4:0] txWrAddr = '0, rxRdAddr = '0;
  logic [7:0] txWrData = '0, rxRdData;

  int checks = 0;
  int errors = 0;
  logic [7:0] sendBuf [32];
  logic [7:0] gotBuf [32];
  logic [7:0] txModel [LEN];
  logic [7:0] rxModel [LEN];

  always #2 clk = ~clk;

  spi_frame_port dut_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .misoOut(misoOut), .misoOe(misoOe), .txArm(txArm), .txWrEn(txWrEn),
    .txWrAddr(txWrAddr), .txWrData(txWrData), .rxEnable(rxEnable),
    .rxRdAddr(rxRdAddr), .rxRdData(rxRdData), .frameDone(frameDone));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTx(input int seed);
    for (int i = 0; i < LEN; i++) begin
      txModel[i] = 8'((i * 37 + seed * 11 + 3) & 255);
      txWrEn = 1'b1; txWrAddr = 5'(i); txWrData = txModel[i];
      tick(1);
    end
    txWrEn = 1'b0;
  endtask

  task automatic xfer(input int n, output logic oeMid);
    oeMid = 1'b0;
    ssNIn = 1'b0;
    tick(12);
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        mosiIn = sendBuf[b][k];
        tick(HALF);
        gotBuf[b][k] = misoOut;
        oeMid = misoOe;
        sckIn = 1'b1;
        tick(HALF);
        sckIn = 1'b0;
      end
    end
    tick(HALF);
    ssNIn = 1'b1;
    tick(10);
  endtask

  task automatic checkRx(input string req);
    for (int a = 0; a < LEN; a++) begin
      rxRdAddr = 5'(a);
      #1;
      check(req, int'(rxRdData), int'(rxModel[a]));
    end
  endtask

  task automatic runCase(input int c, input int n, input logic arm,
                         input logic en, input logic poll);
    logic oeMid;
    logic expDone;
    for (int i = 0; i < 32; i++) sendBuf[i] = 8'((c * 53 + i * 29 + 7) & 255);
    if (poll) sendBuf[0] = 8'h00;
    else if (sendBuf[0] == 8'h00) sendBuf[0] = 8'h01;
    // re-arm receive so done starts clear
    rxEnable = 1'b0; tick(2); rxEnable = 1'b1; tick(2);
    check("R7 done cleared by enable rise", int'(frameDone), 0);
    rxEnable = en;
    txArm = arm;
    tick(2);
    xfer(n, oeMid);
    if (n > 0) check("R6 oe during transaction", int'(oeMid), 1);
    check("R6 oe after release", int'(misoOe), 0);
    for (int b = 0; b < n; b++) begin
      // R1 R2 R3: frame byte while armed and in range, else filler
      check((b == 0) ? "R2 first MISO byte" : "R3 next MISO byte",
            int'(gotBuf[b]), (arm && b < LEN) ? int'(txModel[b]) : 'hFE);
    end
    expDone = en && n > 0 && !poll;
    if (expDone)
      for (int b = 0; b < n && b < LEN; b++) rxModel[b] = sendBuf[b];
    check(poll ? "R4 poll sets no done" : "R6 done flag", int'(frameDone), int'(expDone));
    rxEnable = 1'b0;
    tick(2);
    checkRx(poll ? "R4 poll leaves buffer" : (en ? "R5 R1 receive contents" : "R8 disabled buffer"));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LEN; i++) rxModel[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(3);
    check("R10 reset misoOe", int'(misoOe), 0);
    check("R10 reset frameDone", int'(frameDone), 0);
    checkRx("R10 reset receive buffer");
    loadTx(1);
    runCase(0, 29, 1'b1, 1'b1, 1'b0);  // full frame
    runCase(1, 29, 1'b0, 1'b1, 1'b0);  // filler only
    runCase(2, 5,  1'b1, 1'b1, 1'b0);  // short frame
    runCase(3, 31, 1'b1, 1'b1, 1'b0);  // overlong frame, R5 tail ignored
    runCase(4, 29, 1'b1, 1'b1, 1'b1);  // poll
    runCase(5, 29, 1'b1, 1'b0, 1'b0);  // receive disabled
    runCase(6, 1,  1'b0, 1'b1, 1'b0);  // single byte
    runCase(7, 0,  1'b1, 1'b1, 1'b0);  // empty select
    loadTx(9);                          // R9 rewritten transmit buffer
    runCase(8, 29, 1'b1, 1'b1, 1'b0);
    runCase(9, 3,  1'b1, 1'b1, 1'b1);  // short poll
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule